// File: doc/BRIEF.md
# Carry-Free Signed-Digit Adder

This block adds two N-digit signed-digit numbers whose digits take the values -1, 0 and +1. Each digit is carried on a two-bit pair, and the result is an (N+1)-digit number in the same representation. No carry travels along the word. Each result digit is formed from the input digits at its own position and at the two positions below it, so the logic depth is the same at every width.

The addition runs in two layers of cells. The first layer splits each column's digit sum into a transfer digit and an interim digit. It looks one column down to pick a split that the second layer can absorb. The second layer adds each interim digit to the transfer digit arriving from the column below. The block is purely combinational and is meant as the reduction element of a partial-product tree. Conversion to and from two's complement is left to the surrounding logic.

Top module: `rba_adder`

## Requirements
- R1: Digit i of every operand and of the result sits in bits [2i+1] (positive flag) and [2i] (negative flag), and its value is positive flag minus negative flag. The pattern 2'b11 on an input reads as 0.
- R2: For every pair of inputs, the value of the result, the sum of digit_i * 2^i over N+1 digits, equals the sum of the values of the two operands.
- R3: Every result digit is one of 2'b00, 2'b10, 2'b01. The pattern 2'b11 never appears on the output.
- R4: Column split rule, where t is the sum of the two input digits in a column. For t = +2 or -2, the transfer is +1 or -1 and the interim digit is 0. For t = 0, both are 0. For t = +1, the split is transfer +1 and interim -1 when neither digit one column lower is negative, and otherwise transfer 0 and interim +1. For t = -1, the split is transfer 0 and interim -1 when neither lower digit is negative, and otherwise transfer -1 and interim +1. Column 0 treats its lower column as non-negative.
- R5: Result digit i (i < N) is interim digit i plus the transfer from column i-1, and column 0 receives a transfer of 0. Result digit N is the transfer out of column N-1.
- R6: Result digit i depends only on input columns i, i-1 and i-2. Changing any column below i-2 leaves digit i unchanged.
- R7: An input digit written as 2'b11 gives the same result as the same digit written as 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 2*N | First operand, N signed digits |
| b_i | input | 2*N | Second operand, N signed digits |
| sum_o | output | 2*(N+1) | Signed-digit sum, N+1 digits |

## Verification
At N = 4 the bench sweeps all 65,536 operand pairs, including every placement of the 2'b11 digit. Each result is checked three ways: its integer value against the arithmetic sum, its digit encodings for canonical form, and its individual digits against the split rule. The digit check separates a design that merely sums correctly from one that follows the stated lower-column rule. A separate pass changes only the low columns of the operands and confirms that the upper result digits do not move, which exposes any carry that reaches further than two columns.

// File: rtl/rba_pkg.sv
package rba_pkg;
  typedef logic signed [2:0] dval_t;

  // value of a two-bit digit: positive flag minus negative flag (R1)
  function automatic dval_t dig_val(input logic [1:0] d);
    return $signed({2'b00, d[1]}) - $signed({2'b00, d[0]});
  endfunction

  // canonical encoding of a value in {-1,0,+1}
  function automatic logic [1:0] dig_enc(input dval_t v);
    logic [1:0] e;
    case (v)
      3'sd1:   e = 2'b10;
      -3'sd1:  e = 2'b01;
      default: e = 2'b00;
    endcase
    return e;
  endfunction

  function automatic logic dig_nonneg(input logic [1:0] d);
    return d != 2'b01;
  endfunction

  // transfer digit: floor((t + bias) / 2), bias 1 when the lower column is non-negative
  function automatic dval_t split_xfer(input dval_t t, input logic lo_nonneg);
    dval_t biased;
    biased = t + (lo_nonneg ? 3'sd1 : 3'sd0);
    return biased >>> 1;
  endfunction

  function automatic dval_t split_interim(input dval_t t, input dval_t xfer);
    return t - (xfer <<< 1);
  endfunction
endpackage

// File: rtl/rba_split_cell.sv
module rba_split_cell
  import rba_pkg::*;
(
  input  logic [1:0] x_i,
  input  logic [1:0] y_i,
  input  logic [1:0] lo_x_i,
  input  logic [1:0] lo_y_i,
  output logic [1:0] xfer_o,
  output logic [1:0] interim_o
);
  dval_t col_sum;
  dval_t xfer_v;
  dval_t interim_v;
  logic  lo_nonneg;

  always_comb begin
    col_sum   = dig_val(x_i) + dig_val(y_i);
    lo_nonneg = dig_nonneg(lo_x_i) && dig_nonneg(lo_y_i);
    xfer_v    = split_xfer(col_sum, lo_nonneg);
    interim_v = split_interim(col_sum, xfer_v);
    xfer_o    = dig_enc(xfer_v);
    interim_o = dig_enc(interim_v);
    AST_SPLIT_BALANCE: assert (2 * int'(dig_val(xfer_o)) + int'(dig_val(interim_o))
                               == int'(dig_val(x_i)) + int'(dig_val(y_i))); // R4
    AST_SPLIT_QUIET: assert (!(dig_val(x_i) + dig_val(y_i) == 3'sd0)
                             || (xfer_o == 2'b00 && interim_o == 2'b00)); // R4
  end
endmodule

// File: rtl/rba_merge_cell.sv
module rba_merge_cell
  import rba_pkg::*;
(
  input  logic [1:0] interim_i,
  input  logic [1:0] xfer_in_i,
  output logic [1:0] digit_o
);
  dval_t total;

  always_comb begin
    total   = dig_val(interim_i) + dig_val(xfer_in_i);
    digit_o = dig_enc(total);
    AST_NO_OVERFLOW: assert (total >= -3'sd1 && total <= 3'sd1); // R3
    AST_CANON_DIGIT: assert (digit_o != 2'b11); // R3
  end
endmodule

// File: rtl/rba_adder.sv
module rba_adder
  import rba_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [2*N-1:0]   a_i,
  input  logic [2*N-1:0]   b_i,
  output logic [2*N+1:0]   sum_o
);
  localparam int OUT_DIGITS = N + 1;

  // internal events brought out for the checks
  logic [1:0] xfer_w    [N];
  logic [1:0] interim_w [N];

  for (genvar i = 0; i < N; i++) begin : g_col
    logic [1:0] lo_a;
    logic [1:0] lo_b;
    logic [1:0] xfer_in;
    if (i == 0) begin : g_lsb
      assign lo_a    = 2'b00;
      assign lo_b    = 2'b00;
      assign xfer_in = 2'b00;   // R5: no transfer into column 0
    end else begin : g_upper
      assign lo_a    = a_i[2*i-1 -: 2];
      assign lo_b    = b_i[2*i-1 -: 2];
      assign xfer_in = xfer_w[i-1];
    end

    rba_split_cell u_split (
      .x_i       (a_i[2*i +: 2]),
      .y_i       (b_i[2*i +: 2]),
      .lo_x_i    (lo_a),
      .lo_y_i    (lo_b),
      .xfer_o    (xfer_w[i]),
      .interim_o (interim_w[i])
    );

    rba_merge_cell u_merge (
      .interim_i (interim_w[i]),
      .xfer_in_i (xfer_in),
      .digit_o   (sum_o[2*i +: 2])
    );
  end

  assign sum_o[2*N +: 2] = xfer_w[N-1];  // R5: top digit is the last transfer

  longint val_a;
  longint val_b;
  longint val_s;
  always_comb begin
    val_a = 0;
    val_b = 0;
    val_s = 0;
    for (int k = 0; k < N; k++) begin
      val_a += longint'(dig_val(a_i[2*k +: 2])) <<< k;
      val_b += longint'(dig_val(b_i[2*k +: 2])) <<< k;
    end
    for (int k = 0; k < OUT_DIGITS; k++)
      val_s += longint'(dig_val(sum_o[2*k +: 2])) <<< k;
    AST_VALUE_KEPT: assert (val_s == val_a + val_b); // R2
  end
endmodule

// File: tb/rba_adder_test.sv
module rba_adder_test;
  localparam int N = 4;
  localparam int W = 2 * N;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] a_i;
  logic [W-1:0] b_i;
  logic [W+1:0] sum_o;

  rba_adder #(.N(N)) uut (.a_i(a_i), .b_i(b_i), .sum_o(sum_o));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // R1 decoding, written independently of the design
  function automatic int dv(input logic [1:0] d);
    if (d == 2'b10) return 1;
    if (d == 2'b01) return -1;
    return 0;
  endfunction

  function automatic int value_of(input logic [W+1:0] v, input int digits);
    int acc = 0;
    for (int k = digits - 1; k >= 0; k--) acc = acc * 2 + dv(v[2*k +: 2]);
    return acc;
  endfunction

  // expected result digit per R4/R5, as an integer
  function automatic int exp_digit(input logic [W-1:0] a, input logic [W-1:0] b, input int pos);
    int t, xin, xo, im;
    bit nn;
    xin = 0;
    xo  = 0;
    im  = 0;
    for (int c = 0; c < N; c++) begin
      t  = dv(a[2*c +: 2]) + dv(b[2*c +: 2]);
      nn = (c == 0) ? 1'b1 : (dv(a[2*c-2 +: 2]) >= 0 && dv(b[2*c-2 +: 2]) >= 0);
      case (t)
        2:  begin xo = 1;  im = 0;  end
        -2: begin xo = -1; im = 0;  end
        1:  begin xo = nn ? 1 : 0;  im = nn ? -1 : 1; end
        -1: begin xo = nn ? 0 : -1; im = nn ? -1 : 1; end
        default: begin xo = 0; im = 0; end
      endcase
      if (c == pos) return im + xin;
      xin = xo;
    end
    return xin;  // pos == N
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s a=%h b=%h actual=%0d expected=%0d", req, a_i, b_i, act, expv);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] sa, sb;
    logic [1:0] d3, d4;
    a_i = '0;
    b_i = '0;
    #2;
    check(sum_o == '0, "R1 zero inputs", int'(sum_o), 0);

    // exhaustive sweep
    for (int ia = 0; ia < (1 << W); ia++) begin
      for (int ib = 0; ib < (1 << W); ib++) begin
        bit has11 = 0;
        bit dig_ok = 1;
        bit canon = 1;
        int bad_act = 0, bad_exp = 0;
        a_i = W'(ia);
        b_i = W'(ib);
        #2;
        for (int k = 0; k < N; k++)
          if (a_i[2*k +: 2] == 2'b11 || b_i[2*k +: 2] == 2'b11) has11 = 1;
        check(value_of(sum_o, N + 1) == value_of({2'b00, a_i}, N) + value_of({2'b00, b_i}, N),
              "R2 value", value_of(sum_o, N + 1),
              value_of({2'b00, a_i}, N) + value_of({2'b00, b_i}, N));
        for (int k = 0; k <= N; k++) begin
          if (sum_o[2*k +: 2] == 2'b11) canon = 0;
          if (dv(sum_o[2*k +: 2]) != exp_digit(a_i, b_i, k)) begin
            dig_ok = 0;
            bad_act = dv(sum_o[2*k +: 2]);
            bad_exp = exp_digit(a_i, b_i, k);
          end
        end
        check(canon, "R3 canonical digits", canon, 1);
        if (has11) check(dig_ok, "R7 pattern 11 as zero", bad_act, bad_exp);
        else       check(dig_ok, "R4 R5 digit rule", bad_act, bad_exp);
      end
    end

    // R6: changing low columns leaves upper digits unchanged
    for (int ia = 0; ia < (1 << W); ia += 7) begin
      for (int ib = 0; ib < (1 << W); ib += 11) begin
        sa = W'(ia);
        sb = W'(ib);
        a_i = sa;
        b_i = sb;
        #2;
        d3 = sum_o[7:6];
        d4 = sum_o[9:8];
        a_i = sa;
        b_i = sb;
        a_i[1:0] = sa[1:0] + 2'd1;
        b_i[1:0] = sb[1:0] + 2'd2;
        #2;
        check(sum_o[7:6] == d3, "R6 digit 3 locality", int'(sum_o[7:6]), int'(d3));
        a_i[3:2] = sa[3:2] + 2'd3;
        b_i[3:2] = sb[3:2] + 2'd1;
        #2;
        check(sum_o[9:8] == d4, "R6 digit 4 locality", int'(sum_o[9:8]), int'(d4));
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule